// File: doc/BRIEF.md
# SD Command Path Engine

This block runs the command line of an SD host. When it is idle and receives a start pulse, it builds a 48-bit command frame from a 6-bit index and a 32-bit argument, adds a computed CRC7, and shifts the frame out. It sends one bit on each card-clock strobe, most significant bit first. After the end bit it releases the line and, when the command expects an answer, waits a bounded number of strobes for a response start bit. It then collects a 48-bit short response or a 136-bit long response and checks its CRC.

The card clock is not a clock domain here. The system clock runs the whole block, and `card_stb` is a one-cycle enable that marks a card-clock rising edge. The line output and its enable change only on those cycles, and the line input is sampled only on them. The captured response is presented as four 32-bit words. Four sticky flags report the outcome until software-facing logic clears them with per-flag clear bits.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, `cmd_oe` is 0, `cmd_o` is 1, `busy` is 0 and all four flags are 0. `cmd_oe` is 0 whenever `busy` is 0.
- R2: A `start` pulse while idle sends 48 bits on the next 48 strobes, most significant bit first, with `cmd_oe` high. The bits are 0, 1, the index, the argument, the CRC7 and a closing 1.
- R3: The CRC7 uses the polynomial x^7+x^3+1 with a zero start value and covers the first 40 bits of a frame.
- R4: On the strobe after the closing bit, `cmd_oe` drops to 0. If `rsp_kind` was 2'b00, flag bit 0 (sent) is set at that point and `busy` falls.
- R5: A 0 on `cmd_i` during the first two strobes after release is ignored. A response begins with the first 0 sampled from the third strobe on.
- R6: A response start is accepted up to and including the 64th strobe after release. If none arrives by then, flag bit 3 (timeout) is set on that strobe and the block returns to idle.
- R7: A short response (`rsp_kind` 2'b01) is 48 bits. `rsp_w0` gets frame bits 39..8, `rsp_idx` gets bits 45..40, and `rsp_w1`..`rsp_w3` become 0. Flag bit 1 (response OK) is set when the CRC over bits 47..8 equals bits 7..1 and the end bit is 1.
- R8: When a short response's CRC does not match, flag bit 2 (CRC fail) is set, unless `crc_skip` was 1 at the start, in which case the CRC field is not checked.
- R9: A long response (`rsp_kind` 2'b1x) is 136 bits. {`rsp_w3`,`rsp_w2`,`rsp_w1`,`rsp_w0`} gets frame bits 127..1 followed by a 0. Its CRC covers bits 127..8 only, so the 6-bit header after the direction bit has no effect on the result, and it is compared with bits 7..1.
- R10: A response whose end bit is 0 sets flag bit 2, whatever the CRC and `crc_skip`.
- R11: Each flag stays set until the matching `flag_clr` bit is 1. A set in the same cycle takes priority over a clear.
- R12: A `start` pulse while `busy` is 1 is ignored. The frame in progress is unchanged and no further frame follows.
- R13: `cmd_o` and `cmd_oe` change only on cycles where `card_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_stb | input | 1 | One-cycle strobe marking a card-clock rising edge |
| start | input | 1 | Begin a command when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 00 none, 01 short, 1x long |
| crc_skip | input | 1 | Do not check the CRC of a short response |
| flag_clr | input | 4 | Per-flag clear bits |
| cmd_i | input | 1 | Command line as received |
| cmd_o | output | 1 | Command line value driven |
| cmd_oe | output | 1 | Command line driver enable |
| busy | output | 1 | A command or response is in progress |
| flags | output | 4 | bit0 sent, bit1 response OK, bit2 CRC fail, bit3 timeout |
| rsp_idx | output | 6 | Index field of the last short response |
| rsp_w0 | output | 32 | Response word 0 (lowest) |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 (highest) |

## Verification
A corrupt shift register or bit counter shows on `cmd_o` within one strobe: a bit is wrong, or `cmd_oe` drops early or late around the 48th bit. A wrong receive counter or CRC window shows only at the end of a response, when the wrong flag is raised or a payload word is shifted. These are checked against bench-computed frames for both response lengths. The wait counter is checked at both edges of its window, the second strobe and the 64th strobe, where an off-by-one changes the outcome between accept, ignore and timeout.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_TURN,
        ST_WAIT,
        ST_RX
    } sdcmd_st_e;

    localparam int FL_SENT = 0;
    localparam int FL_OK   = 1;
    localparam int FL_CRC  = 2;
    localparam int FL_TMO  = 3;
    localparam int FL_N    = 4;

    // one serial step of the x^7 + x^3 + 1 remainder
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

endpackage

// File: rtl/sdcmd_frame.sv
module sdcmd_frame
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    localparam int HDR_W = 2 + IDX_W + ARG_W,
    localparam int FRM_W = HDR_W + 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic [FRM_W-1:0] frame
);

    logic [HDR_W-1:0] hdr;
    logic [6:0]       crc;

    always_comb begin
        hdr = {2'b01, idx, arg};
        crc = 7'h00;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            crc = crc7_step(crc, hdr[i]);
        end
        frame = {hdr, crc, 1'b1};
    end

endmodule

// File: rtl/sdcmd_flags.sv
module sdcmd_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    logic [N-1:0] flg_d, flg_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        always_comb flg_d[k] = set[k] | (flg_q[k] & ~clr[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TMO_CLKS = 64,
    parameter int TURN_MIN = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        card_stb,
    input  logic        start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic [1:0]  rsp_kind,
    input  logic        crc_skip,
    input  logic [3:0]  flag_clr,
    input  logic        cmd_i,
    output logic        cmd_o,
    output logic        cmd_oe,
    output logic        busy,
    output logic [3:0]  flags,
    output logic [5:0]  rsp_idx,
    output logic [31:0] rsp_w0,
    output logic [31:0] rsp_w1,
    output logic [31:0] rsp_w2,
    output logic [31:0] rsp_w3
);

    localparam int CMD_LEN  = 48;
    localparam int SRSP_LEN = 48;
    localparam int LRSP_LEN = 136;
    localparam int RSP_W    = 32;
    localparam int RSP_BITS = RSP_W * 4;
    localparam int CNT_MAX  = (TMO_CLKS > LRSP_LEN) ? TMO_CLKS : LRSP_LEN;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    typedef struct packed {
        sdcmd_st_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [CMD_LEN-1:0]    tx_sr;
        logic [RSP_BITS-2:0]   rx_sr;
        logic [6:0]            crc;
        logic                  has_rsp;
        logic                  long_rsp;
        logic                  skip;
        logic                  line_o;
        logic                  line_oe;
        logic [RSP_BITS-1:0]   rsp;
        logic [5:0]            ridx;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:       ST_IDLE,
        cnt:      '0,
        tx_sr:    '0,
        rx_sr:    '0,
        crc:      '0,
        has_rsp:  1'b0,
        long_rsp: 1'b0,
        skip:     1'b0,
        line_o:   1'b1,
        line_oe:  1'b0,
        rsp:      '0,
        ridx:     '0
    };

    ctl_t               ctl_d, ctl_q;
    logic [CMD_LEN-1:0] frame;
    logic [FL_N-1:0]    fl_set;
    logic               rx_last;
    logic               rx_in_crc;
    logic               crc_pass;

    sdcmd_frame #(
        .IDX_W (6),
        .ARG_W (32)
    ) u_frame (
        .idx   (cmd_index),
        .arg   (cmd_arg),
        .frame (frame)
    );

    sdcmd_flags #(
        .N (FL_N)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    always_comb begin
        ctl_d  = ctl_q;
        fl_set = '0;

        rx_last   = ctl_q.long_rsp ? (ctl_q.cnt == CNT_W'(LRSP_LEN - 1))
                                   : (ctl_q.cnt == CNT_W'(SRSP_LEN - 1));
        rx_in_crc = ctl_q.long_rsp ? ((ctl_q.cnt >= CNT_W'(8)) &&
                                      (ctl_q.cnt <  CNT_W'(LRSP_LEN - 8)))
                                   : (ctl_q.cnt <  CNT_W'(SRSP_LEN - 8));
        crc_pass  = cmd_i && ((ctl_q.crc == ctl_q.rx_sr[6:0]) ||
                              (!ctl_q.long_rsp && ctl_q.skip));

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st       = ST_TX;
                    ctl_d.cnt      = '0;
                    ctl_d.tx_sr    = frame;
                    ctl_d.has_rsp  = |rsp_kind;
                    ctl_d.long_rsp = rsp_kind[1];
                    ctl_d.skip     = crc_skip;
                end
            end
            ST_TX: begin
                if (card_stb) begin
                    ctl_d.line_o  = ctl_q.tx_sr[CMD_LEN-1];
                    ctl_d.line_oe = 1'b1;
                    ctl_d.tx_sr   = {ctl_q.tx_sr[CMD_LEN-2:0], 1'b0};
                    ctl_d.cnt     = ctl_q.cnt + CNT_W'(1);
                    if (ctl_q.cnt == CNT_W'(CMD_LEN - 1)) begin
                        ctl_d.st = ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                if (card_stb) begin
                    ctl_d.line_oe = 1'b0;
                    ctl_d.line_o  = 1'b1;
                    ctl_d.cnt     = '0;
                    if (ctl_q.has_rsp) begin
                        ctl_d.st = ST_WAIT;
                    end else begin
                        ctl_d.st        = ST_IDLE;
                        fl_set[FL_SENT] = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (card_stb) begin
                    if ((ctl_q.cnt >= CNT_W'(TURN_MIN)) && !cmd_i) begin
                        ctl_d.st    = ST_RX;
                        ctl_d.cnt   = CNT_W'(1);
                        ctl_d.crc   = '0;
                        ctl_d.rx_sr = '0;
                    end else if (ctl_q.cnt == CNT_W'(TMO_CLKS - 1)) begin
                        ctl_d.st       = ST_IDLE;
                        fl_set[FL_TMO] = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_RX: begin
                if (card_stb) begin
                    ctl_d.rx_sr = {ctl_q.rx_sr[RSP_BITS-3:0], cmd_i};
                    ctl_d.cnt   = ctl_q.cnt + CNT_W'(1);
                    if (rx_in_crc) begin
                        ctl_d.crc = crc7_step(ctl_q.crc, cmd_i);
                    end
                    if (rx_last) begin
                        ctl_d.st = ST_IDLE;
                        if (ctl_q.long_rsp) begin
                            ctl_d.rsp = {ctl_q.rx_sr, 1'b0};
                        end else begin
                            ctl_d.rsp  = {{(RSP_BITS - RSP_W){1'b0}}, ctl_q.rx_sr[38:7]};
                            ctl_d.ridx = ctl_q.rx_sr[44:39];
                        end
                        fl_set[FL_OK]  = crc_pass;
                        fl_set[FL_CRC] = !crc_pass;
                    end
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign cmd_o   = ctl_q.line_o;
    assign cmd_oe  = ctl_q.line_oe;
    assign busy    = (ctl_q.st != ST_IDLE);
    assign rsp_idx = ctl_q.ridx;
    assign rsp_w0  = ctl_q.rsp[RSP_W-1:0];
    assign rsp_w1  = ctl_q.rsp[2*RSP_W-1:RSP_W];
    assign rsp_w2  = ctl_q.rsp[3*RSP_W-1:2*RSP_W];
    assign rsp_w3  = ctl_q.rsp[4*RSP_W-1:3*RSP_W];

endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       card_stb,
    input logic [3:0] flag_clr,
    input logic       cmd_o,
    input logic       cmd_oe,
    input logic       busy,
    input logic [3:0] flags
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_oe);

    p_first_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> (cmd_o == 1'b0));

    p_release_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> ($past(cmd_o) == 1'b1));

    p_done_reports_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flags != 4'b0));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~flag_clr)) |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 4'b0));

    p_line_on_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !card_stb |=> ($stable(cmd_o) && $stable(cmd_oe)));

endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_stb (card_stb),
    .flag_clr (flag_clr),
    .cmd_o    (cmd_o),
    .cmd_oe   (cmd_oe),
    .busy     (busy),
    .flags    (flags)
);

// File: tb/sdcmd_engine_tb.sv
`timescale 1ns/1ps
module sdcmd_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_stb = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [1:0]  rsp_kind = '0;
    logic        crc_skip = 1'b0;
    logic [3:0]  flag_clr = '0;
    logic        cmd_i = 1'b1;
    logic        cmd_o, cmd_oe, busy;
    logic [3:0]  flags;
    logic [5:0]  rsp_idx;
    logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;

    int nvec = 0;
    int nfail = 0;
    int stab_err = 0;

    always #2 clk = ~clk;

    sdcmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .card_stb(card_stb), .start(start),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind),
        .crc_skip(crc_skip), .flag_clr(flag_clr), .cmd_i(cmd_i),
        .cmd_o(cmd_o), .cmd_oe(cmd_oe), .busy(busy), .flags(flags),
        .rsp_idx(rsp_idx), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1),
        .rsp_w2(rsp_w2), .rsp_w3(rsp_w3)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // remainder of (msg * x^7) modulo x^7+x^3+1, by long division
    function automatic logic [6:0] crc_div(input logic [119:0] m, input int n);
        logic [7:0] r;
        r = 8'h00;
        for (int i = n - 1; i >= 0; i--) begin
            r = {r[6:0], m[i]};
            if (r[7]) r = r ^ 8'h89;
        end
        for (int i = 0; i < 7; i++) begin
            r = {r[6:0], 1'b0};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    task automatic tick();
        logic o1, e1;
        card_stb = 1'b1;
        @(negedge clk);
        card_stb = 1'b0;
        o1 = cmd_o;
        e1 = cmd_oe;
        repeat (3) @(negedge clk);
        if (o1 !== cmd_o || e1 !== cmd_oe) stab_err++;
    endtask

    task automatic clear_all();
        flag_clr = 4'hF;
        @(negedge clk);
        flag_clr = 4'h0;
    endtask

    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] a,
                            input logic [1:0] k, input bit sk, input bit inject);
        logic [47:0] f;
        int bad;
        f = {2'b01, idx, a, crc_div({80'b0, 2'b01, idx, a}, 40), 1'b1};
        cmd_index = idx; cmd_arg = a; rsp_kind = k; crc_skip = sk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int b = 47; b >= 0; b--) begin
            if (inject && b == 30) begin
                cmd_index = ~idx; cmd_arg = ~a; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            tick();
            if (cmd_oe !== 1'b1 || cmd_o !== f[b]) bad++;
        end
        chk(bad == 0, inject ? "R12 frame intact" : "R2/R3 frame bits", 128'(bad), 128'(0));
        cmd_i = 1'b1;
        tick();
        chk(cmd_oe == 1'b0, "R4 release", 128'(cmd_oe), 128'(0));
    endtask

    task automatic reply(input logic [135:0] fr, input int len, input int delay,
                         input bit glitch);
        for (int i = 0; i < delay; i++) begin
            cmd_i = (glitch && i < 2) ? 1'b0 : 1'b1;
            tick();
        end
        for (int b = len - 1; b >= 0; b--) begin
            cmd_i = fr[b];
            tick();
        end
        cmd_i = 1'b1;
    endtask

    function automatic logic [135:0] short_frame(input logic [5:0] idx, input logic [31:0] p);
        logic [39:0] h;
        h = {2'b00, idx, p};
        return {88'b0, h, crc_div({80'b0, h}, 40), 1'b1};
    endfunction

    localparam logic [119:0] LPAY = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A};

    function automatic logic [135:0] long_frame(input logic [119:0] p);
        return {2'b00, 6'h3F, p, crc_div(p, 120), 1'b1};
    endfunction

    task automatic t_reset();
        chk(flags == 4'h0 && !busy, "R1 reset flags/busy", {busy, flags}, 0);
        chk(cmd_oe == 1'b0 && cmd_o == 1'b1, "R1 reset line", {cmd_oe, cmd_o}, 2'b01);
    endtask

    task automatic t_no_rsp();
        clear_all();
        send_cmd(6'd0, 32'h0000_0000, 2'b00, 1'b0, 1'b0);
        chk(flags == 4'b0001 && !busy, "R4 sent flag", {busy, flags}, 4'b0001);
        send_cmd(6'h3F, 32'hFFFF_FFFF, 2'b00, 1'b0, 1'b0);
        send_cmd(6'd17, 32'h1234_5678, 2'b00, 1'b0, 1'b0);
        chk(flags == 4'b0001, "R3 sent after varied frames", flags, 4'b0001);
    endtask

    task automatic t_short_ok();
        clear_all();
        send_cmd(6'd2, 32'h0000_00AA, 2'b01, 1'b0, 1'b0);
        reply(short_frame(6'd2, 32'hCAFE_F00D), 48, 5, 1'b0);
        chk(flags == 4'b0010 && !busy, "R7 short ok flag", {busy, flags}, 4'b0010);
        chk(rsp_w0 == 32'hCAFE_F00D, "R7 short payload", rsp_w0, 32'hCAFE_F00D);
        chk(rsp_idx == 6'd2 && {rsp_w3, rsp_w2, rsp_w1} == 96'b0, "R7 short idx/upper",
            {rsp_idx, rsp_w3, rsp_w2, rsp_w1}, {6'd2, 96'b0});
    endtask

    task automatic t_short_bad();
        logic [135:0] fr;
        clear_all();
        fr = short_frame(6'd13, 32'h0BAD_C0DE);
        fr[3] = ~fr[3];
        send_cmd(6'd13, 32'h1, 2'b01, 1'b0, 1'b0);
        reply(fr, 48, 3, 1'b0);
        chk(flags == 4'b0100, "R8 short crc mismatch", flags, 4'b0100);
        clear_all();
        fr[7:1] = 7'h7F;
        send_cmd(6'd41, 32'h2, 2'b01, 1'b1, 1'b0);
        reply(fr, 48, 3, 1'b0);
        chk(flags == 4'b0010, "R8 short crc skipped", flags, 4'b0010);
        chk(rsp_w0 == 32'h0BAD_C0DE && rsp_idx == 6'd13, "R8 skipped payload",
            {rsp_idx, rsp_w0}, {6'd13, 32'h0BAD_C0DE});
    endtask

    task automatic t_end_zero();
        logic [135:0] fr;
        clear_all();
        fr = short_frame(6'd7, 32'h5555_AAAA);
        fr[0] = 1'b0;
        send_cmd(6'd7, 32'h3, 2'b01, 1'b1, 1'b0);
        reply(fr, 48, 4, 1'b0);
        chk(flags == 4'b0100, "R10 end bit zero", flags, 4'b0100);
    endtask

    task automatic t_long();
        logic [135:0] fr;
        clear_all();
        fr = long_frame(LPAY);
        send_cmd(6'd9, 32'hFFFF_0000, 2'b10, 1'b0, 1'b0);
        reply(fr, 136, 63, 1'b0);
        chk(flags == 4'b0010, "R6/R9 long ok at last window strobe", flags, 4'b0010);
        chk({rsp_w3, rsp_w2, rsp_w1, rsp_w0} == {fr[127:1], 1'b0}, "R9 long words",
            {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, {fr[127:1], 1'b0});
        clear_all();
        fr[133:128] = 6'h15;
        send_cmd(6'd10, 32'h1, 2'b11, 1'b0, 1'b0);
        reply(fr, 136, 2, 1'b0);
        chk(flags == 4'b0010, "R9 header outside crc", flags, 4'b0010);
        clear_all();
        fr[60] = ~fr[60];
        send_cmd(6'd10, 32'h1, 2'b10, 1'b1, 1'b0);
        reply(fr, 136, 2, 1'b0);
        chk(flags == 4'b0100, "R9 long crc mismatch", flags, 4'b0100);
    endtask

    task automatic t_timeout();
        clear_all();
        send_cmd(6'd5, 32'h0, 2'b01, 1'b0, 1'b0);
        cmd_i = 1'b1;
        repeat (63) tick();
        chk(flags == 4'b0000 && busy, "R6 still waiting at 63", {busy, flags}, 5'b10000);
        tick();
        chk(flags == 4'b1000 && !busy, "R6 timeout at 64", {busy, flags}, 5'b01000);
    endtask

    task automatic t_glitch();
        clear_all();
        send_cmd(6'd3, 32'h0, 2'b01, 1'b0, 1'b0);
        reply(short_frame(6'd3, 32'h1357_9BDF), 48, 2, 1'b1);
        chk(flags == 4'b0010 && rsp_w0 == 32'h1357_9BDF, "R5 early zeros ignored",
            {flags, rsp_w0}, {4'b0010, 32'h1357_9BDF});
    endtask

    task automatic t_busy_start();
        int moved;
        clear_all();
        send_cmd(6'd21, 32'hA5A5_0F0F, 2'b00, 1'b0, 1'b1);
        chk(flags == 4'b0001 && !busy, "R12 one frame only", {busy, flags}, 5'b00001);
        moved = 0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (cmd_oe !== 1'b0 || busy !== 1'b0) moved++;
        end
        chk(moved == 0, "R12 no second frame", 128'(moved), 128'(0));
    endtask

    task automatic t_flag_clear();
        logic [135:0] fr;
        clear_all();
        send_cmd(6'd1, 32'h0, 2'b00, 1'b0, 1'b0);
        fr = short_frame(6'd1, 32'h0);
        fr[1] = ~fr[1];
        send_cmd(6'd1, 32'h0, 2'b01, 1'b0, 1'b0);
        reply(fr, 48, 3, 1'b0);
        chk(flags == 4'b0101, "R11 flags accumulate", flags, 4'b0101);
        flag_clr = 4'b0100;
        @(negedge clk);
        flag_clr = 4'b0000;
        repeat (3) @(negedge clk);
        chk(flags == 4'b0001, "R11 selective clear", flags, 4'b0001);
        clear_all();
        chk(flags == 4'b0000, "R11 clear all", flags, 4'b0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_rsp();
        t_short_ok();
        t_short_bad();
        t_end_zero();
        t_long();
        t_timeout();
        t_glitch();
        t_busy_start();
        t_flag_clear();
        chk(stab_err == 0, "R13 line changes only on strobe", 128'(stab_err), 128'(0));
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule